// File: doc/BRIEF.md
# Ring MAC Command Register Sequencer

This block is the control register that a host writes to steer the transmitter and receiver of a token-ring MAC. It holds four request bits: master reset, MAC reset, beacon request and claim request. The host raises a request by writing a one to its bit. The block then settles which pending request wins and sends single-cycle force strobes to the transmitter and receiver state machines. It clears each bit when its action finishes, or when the transmitter reports that it has entered the target state.

The block also watches the frame being sent when a MAC reset takes effect. From the byte phase of that frame it decides whether the frame is aborted and whether the ending-delimiter byte is held back. After a beacon or claim force, it keeps externally supplied frames blocked until one internally built frame has gone out. All pins are plain control and status lines with no streaming data, so no valid/ready handshake and no back-pressure apply.

Top module: `ring_cmd_seq`

## Requirements
- R1: After reset the register reads 0x00 and every output is low.
- R2: Only bit positions 0, 2, 3 and 4 at address 0x02 are writable. A write to bit 1, 5, 6 or 7, or a write to any other address, changes nothing, produces no strobe, and reads back as zero. The read data is zero for any address other than 0x02.
- R3: Writing bit 0 (master reset) pulses `cfg_clear_o` and `timer_dflt_o` for one cycle on the clock after the write. The same clock sets bit 2 and clears bits 3 and 4. Bit 0 reads one for MRST_CYCLES clocks after the write and then clears, and the register then reads 0x00.
- R4: While bit 2 (MAC reset) is set, the next clock issues a one-cycle `mac_rst_o` pulse (transmitter Idle, receiver Listen) and clears bit 2.
- R5: Writing bit 3 (beacon) also sets bit 2. `mac_rst_o` comes first, and one clock later `force_beacon_o` pulses once. Bit 3 clears on `enter_beacon_i`.
- R6: Writing bit 4 (claim) while not in Beacon and with bit 3 clear pulses `force_claim_o` once, on the clock after the bit is set. Bit 4 clears on `enter_claim_i` or `enter_beacon_i`.
- R7: While `txs_beacon_i` is high, a pending claim is held and is taken on the clock after `my_beacon_i` is seen. While bit 3 is set, no claim force is issued.
- R8: A pending MAC reset blocks beacon and claim forces but leaves bits 3 and 4 set. A beacon or claim already forced but not yet entered is forced again after the MAC reset. At most one of `mac_rst_o`, `force_beacon_o` and `force_claim_o` is high in any cycle.
- R9: The MAC reset pulse is accompanied by `tx_abort_o` when `frm_active_i` is high and the frame phase is not 2 (A/C byte). `ed_suppress_o` is raised as well when the phase is 1 (ED/E byte). The phase encoding is 0 body, 1 ED/E byte, 2 A/C byte, 3 none.
- R10: `ext_ok_o` rises on the clock after the first `frm_sent_i` that follows a beacon or claim force, and it drops on the next force of any kind.
- R11: Writing one to a bit that is already set starts no second action. Writing zero does not cancel a pending request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| host_wr_i | input | 1 | Host write strobe |
| host_addr_i | input | ADDR_W | Host address for read and write |
| host_wdata_i | input | 8 | Host write data |
| host_rdata_o | output | 8 | Read data for host_addr_i |
| txs_beacon_i | input | 1 | Transmitter currently in Beacon state |
| my_beacon_i | input | 1 | Own beacon frame received |
| enter_claim_i | input | 1 | Transmitter entered Claim |
| enter_beacon_i | input | 1 | Transmitter entered Beacon |
| frm_active_i | input | 1 | A frame is being transmitted |
| frm_phase_i | input | 2 | Byte phase of the frame in progress |
| frm_sent_i | input | 1 | An internally built frame finished sending |
| mac_rst_o | output | 1 | Strobe: transmitter to Idle, receiver to Listen |
| force_beacon_o | output | 1 | Strobe: transmitter to Beacon |
| force_claim_o | output | 1 | Strobe: transmitter to Claim |
| cfg_clear_o | output | 1 | Strobe: clear mode, option, event and mask registers |
| timer_dflt_o | output | 1 | Strobe: load timer defaults |
| tx_abort_o | output | 1 | Strobe: abort the frame in progress |
| ed_suppress_o | output | 1 | Strobe: withhold the ending-delimiter byte |
| ext_ok_o | output | 1 | Externally supplied beacon/claim frames allowed |

## Verification
The hardest case to reach is a MAC reset that arrives between a beacon force and the transmitter's entry into Beacon, because the beacon bit must survive and be forced a second time. The bench reaches it by writing the beacon bit and holding back `enter_beacon_i`. It then writes the MAC reset bit and watches for a second beacon strobe. Held claims are driven by random combinations of the in-Beacon and own-beacon-received levels, so that both the held outcome and the taken outcome occur.

// File: rtl/ring_cmd_pkg.sv
package ring_cmd_pkg;
  localparam int unsigned REG_W = 8;
  localparam int unsigned NCMD  = 4;
  localparam int unsigned C_MARST = 0;
  localparam int unsigned C_MCRST = 1;
  localparam int unsigned C_BCN   = 2;
  localparam int unsigned C_CLM   = 3;

  typedef enum logic [1:0] {
    PH_BODY = 2'd0,
    PH_EDE  = 2'd1,
    PH_AC   = 2'd2,
    PH_NONE = 2'd3
  } frm_phase_e;

  // register bit position for each command index
  function automatic int unsigned bit_pos(input int unsigned idx);
    case (idx)
      C_MARST: bit_pos = 0;
      C_MCRST: bit_pos = 2;
      C_BCN:   bit_pos = 3;
      default: bit_pos = 4;
    endcase
  endfunction
endpackage

// File: rtl/cmd_regfile.sv
module cmd_regfile
  import ring_cmd_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CMD_ADDR = 8'h02
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  input  logic              mst_start_i,
  input  logic [NCMD-1:0]   clr_i,
  output logic [NCMD-1:0]   q_o
);
  logic            hit;
  logic [NCMD-1:0] set;

  assign hit = wr_i && (addr_i == CMD_ADDR);

  always_comb begin
    for (int i = 0; i < NCMD; i++) set[i] = hit && wdata_i[bit_pos(i)];
    // beacon write and master reset both raise the MAC reset request
    set[C_MCRST] = set[C_MCRST] || set[C_BCN] || mst_start_i;
  end

  for (genvar g = 0; g < NCMD; g++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) bit_q <= 1'b0;
      else         bit_q <= set[g] || (bit_q && !clr_i[g]);
    end
    assign q_o[g] = bit_q;
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == CMD_ADDR)
      for (int i = 0; i < NCMD; i++) rdata_o[bit_pos(i)] = q_o[i];
  end

  AST_BCN_SETS_MCRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && wdata_i[bit_pos(C_BCN)]) |=> q_o[C_MCRST]); // R5
  AST_ZERO_NO_CANCEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_o[C_CLM] && !clr_i[C_CLM]) |=> q_o[C_CLM]); // R11
endmodule

// File: rtl/cmd_arbiter.sv
module cmd_arbiter
  import ring_cmd_pkg::*;
#(
  parameter int unsigned MRST_CYCLES = 4,
  localparam int unsigned CNT_W = $clog2(MRST_CYCLES + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NCMD-1:0] q_i,
  input  logic            txs_beacon_i,
  input  logic            my_beacon_i,
  input  logic            enter_claim_i,
  input  logic            enter_beacon_i,
  output logic            mst_start_o,
  output logic [NCMD-1:0] clr_o,
  output logic            grant_idle_o,
  output logic            grant_bcn_o,
  output logic            grant_clm_o,
  output logic            mac_rst_o,
  output logic            force_beacon_o,
  output logic            force_claim_o,
  output logic            cfg_clear_o,
  output logic            timer_dflt_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             mst_done;
  logic             bcn_iss_q, clm_iss_q;
  logic             claim_open;

  assign mst_start_o = q_i[C_MARST] && (cnt_q == '0);
  assign mst_done    = q_i[C_MARST] && (cnt_q == CNT_W'(MRST_CYCLES - 1));

  // precedence: MAC reset, then beacon, then claim
  assign claim_open   = !txs_beacon_i || my_beacon_i;
  assign grant_idle_o = q_i[C_MCRST];
  assign grant_bcn_o  = !mst_start_o && !q_i[C_MCRST] && q_i[C_BCN] && !bcn_iss_q;
  assign grant_clm_o  = !mst_start_o && !q_i[C_MCRST] && !q_i[C_BCN] && q_i[C_CLM]
                        && !clm_iss_q && claim_open;

  always_comb begin
    clr_o          = '0;
    clr_o[C_MARST] = mst_done;
    clr_o[C_MCRST] = grant_idle_o;
    clr_o[C_BCN]   = enter_beacon_i || mst_start_o;
    clr_o[C_CLM]   = enter_claim_i || enter_beacon_i || mst_start_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q          <= '0;
      bcn_iss_q      <= 1'b0;
      clm_iss_q      <= 1'b0;
      mac_rst_o      <= 1'b0;
      force_beacon_o <= 1'b0;
      force_claim_o  <= 1'b0;
      cfg_clear_o    <= 1'b0;
      timer_dflt_o   <= 1'b0;
    end else begin
      if (!q_i[C_MARST] || mst_done) cnt_q <= '0;
      else                           cnt_q <= cnt_q + 1'b1;
      if (grant_idle_o || !q_i[C_BCN]) bcn_iss_q <= 1'b0;
      else if (grant_bcn_o)            bcn_iss_q <= 1'b1;
      if (grant_idle_o || !q_i[C_CLM]) clm_iss_q <= 1'b0;
      else if (grant_clm_o)            clm_iss_q <= 1'b1;
      mac_rst_o      <= grant_idle_o;
      force_beacon_o <= grant_bcn_o;
      force_claim_o  <= grant_clm_o;
      cfg_clear_o    <= mst_start_o;
      timer_dflt_o   <= mst_start_o;
    end
  end

  AST_ONE_FORCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({mac_rst_o, force_beacon_o, force_claim_o})); // R8
  AST_CLAIM_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_claim_o |-> $past(!q_i[C_BCN] && (!txs_beacon_i || my_beacon_i))); // R7
  AST_MRST_SETS_MCRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_clear_o |-> q_i[C_MCRST]); // R3
  AST_BCN_FROM_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(force_beacon_o) |-> $past(q_i[C_BCN] && !q_i[C_MCRST])); // R5
endmodule

// File: rtl/frame_guard.sv
module frame_guard
  import ring_cmd_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       grant_idle_i,
  input  logic       grant_bcn_i,
  input  logic       grant_clm_i,
  input  logic       frm_active_i,
  input  logic [1:0] frm_phase_i,
  input  logic       frm_sent_i,
  output logic       tx_abort_o,
  output logic       ed_suppress_o,
  output logic       ext_ok_o
);
  frm_phase_e phase;
  logic       armed_q;
  logic       any_grant;

  assign phase     = frm_phase_e'(frm_phase_i);
  assign any_grant = grant_idle_i || grant_bcn_i || grant_clm_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_abort_o    <= 1'b0;
      ed_suppress_o <= 1'b0;
      armed_q       <= 1'b0;
      ext_ok_o      <= 1'b0;
    end else begin
      // A/C indicators still go out; ED/E byte is withheld
      tx_abort_o    <= grant_idle_i && frm_active_i && (phase != PH_AC);
      ed_suppress_o <= grant_idle_i && frm_active_i && (phase == PH_EDE);
      if (any_grant) begin
        ext_ok_o <= 1'b0;
        armed_q  <= grant_bcn_i || grant_clm_i;
      end else if (armed_q && frm_sent_i) begin
        ext_ok_o <= 1'b1;
        armed_q  <= 1'b0;
      end
    end
  end

  AST_AC_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_abort_o |-> $past(frm_phase_i != PH_AC)); // R9
  AST_EXT_AFTER_SENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ext_ok_o) |-> $past(frm_sent_i)); // R10
endmodule

// File: rtl/ring_cmd_seq.sv
module ring_cmd_seq
  import ring_cmd_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CMD_ADDR = 8'h02,
  parameter int unsigned MRST_CYCLES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_wr_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic [7:0]        host_wdata_i,
  output logic [7:0]        host_rdata_o,
  input  logic              txs_beacon_i,
  input  logic              my_beacon_i,
  input  logic              enter_claim_i,
  input  logic              enter_beacon_i,
  input  logic              frm_active_i,
  input  logic [1:0]        frm_phase_i,
  input  logic              frm_sent_i,
  output logic              mac_rst_o,
  output logic              force_beacon_o,
  output logic              force_claim_o,
  output logic              cfg_clear_o,
  output logic              timer_dflt_o,
  output logic              tx_abort_o,
  output logic              ed_suppress_o,
  output logic              ext_ok_o
);
  logic [NCMD-1:0] q, clr;
  logic            mst_start, g_idle, g_bcn, g_clm;

  cmd_regfile #(.ADDR_W(ADDR_W), .CMD_ADDR(CMD_ADDR)) u_regs (
    .clk_i, .rst_ni,
    .wr_i(host_wr_i), .addr_i(host_addr_i), .wdata_i(host_wdata_i),
    .rdata_o(host_rdata_o), .mst_start_i(mst_start), .clr_i(clr), .q_o(q)
  );

  cmd_arbiter #(.MRST_CYCLES(MRST_CYCLES)) u_arb (
    .clk_i, .rst_ni, .q_i(q),
    .txs_beacon_i, .my_beacon_i, .enter_claim_i, .enter_beacon_i,
    .mst_start_o(mst_start), .clr_o(clr),
    .grant_idle_o(g_idle), .grant_bcn_o(g_bcn), .grant_clm_o(g_clm),
    .mac_rst_o, .force_beacon_o, .force_claim_o, .cfg_clear_o, .timer_dflt_o
  );

  frame_guard u_guard (
    .clk_i, .rst_ni,
    .grant_idle_i(g_idle), .grant_bcn_i(g_bcn), .grant_clm_i(g_clm),
    .frm_active_i, .frm_phase_i, .frm_sent_i,
    .tx_abort_o, .ed_suppress_o, .ext_ok_o
  );
endmodule

// File: tb/test_ring_cmd_seq.sv
module test_ring_cmd_seq;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       wr = 1'b0;
  logic [7:0] addr = 8'h02, wdata = 8'h00, rdata;
  logic       inb = 1'b0, myb = 1'b0, ent_clm = 1'b0, ent_bcn = 1'b0;
  logic       fact = 1'b0, fsent = 1'b0;
  logic [1:0] fph = 2'd3;
  logic       o_mrst, o_fb, o_fc, o_cfg, o_tmr, o_abort, o_supp, o_ext;
  int         checks = 0, errors = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  ring_cmd_seq i_ring_cmd_seq (
    .clk_i(clk), .rst_ni(rst_n), .host_wr_i(wr), .host_addr_i(addr),
    .host_wdata_i(wdata), .host_rdata_o(rdata),
    .txs_beacon_i(inb), .my_beacon_i(myb), .enter_claim_i(ent_clm),
    .enter_beacon_i(ent_bcn), .frm_active_i(fact), .frm_phase_i(fph),
    .frm_sent_i(fsent), .mac_rst_o(o_mrst), .force_beacon_o(o_fb),
    .force_claim_o(o_fc), .cfg_clear_o(o_cfg), .timer_dflt_o(o_tmr),
    .tx_abort_o(o_abort), .ed_suppress_o(o_supp), .ext_ok_o(o_ext)
  );

  function automatic logic [7:0] outs();
    return {o_mrst, o_fb, o_fc, o_cfg, o_tmr, o_abort, o_supp, o_ext};
  endfunction

  function automatic bit claim_taken(input bit in_bcn, input bit own_back);
    return !in_bcn || own_back;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr = 1'b1;
    step();
    wr = 1'b0; addr = 8'h02;
  endtask

  task automatic pulse_enter_claim();
    ent_clm = 1'b1; step(); ent_clm = 1'b0; step();
  endtask

  task automatic pulse_enter_beacon();
    ent_bcn = 1'b1; step(); ent_bcn = 1'b0; step();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) step();
    rst_n = 1'b1;
    step();
    check("R1 read", rdata, 8'h00);
    check("R1 outputs", outs(), 8'h00);

    // R2 reserved bits and foreign addresses
    wr_reg(8'h02, 8'hE2);
    check("R2 reserved read", rdata, 8'h00);
    step();
    check("R2 reserved strobes", outs(), 8'h00);
    for (int i = 0; i < 16; i++) begin
      logic [7:0] a, d;
      if (i % 2 == 0) begin a = 8'h02; d = 8'($urandom) & 8'hE2; end
      else begin a = 8'($urandom); if (a == 8'h02) a = 8'h03; d = 8'($urandom); end
      wr_reg(a, d);
      check("R2 random read", rdata, 8'h00);
      step();
      check("R2 random strobes", outs(), 8'h00);
    end
    addr = 8'h05;
    check("R2 other address reads zero", rdata, 8'h00);
    addr = 8'h02;

    // R4 MAC reset
    wr_reg(8'h02, 8'h04);
    check("R4 bit set", rdata, 8'h04);
    step();
    check("R4 strobe", {o_mrst, o_fb, o_fc}, 8'h04);
    check("R4 bit cleared", rdata, 8'h00);
    step();
    check("R4 single cycle", {7'd0, o_mrst}, 8'h00);

    // R9 frame phase handling
    fact = 1'b1;
    for (int p = 0; p < 3; p++) begin
      fph = 2'(p);
      wr_reg(8'h02, 8'h04);
      step();
      check("R9 abort/suppress", {6'd0, o_abort, o_supp},
            (p == 0) ? 8'h02 : (p == 1) ? 8'h03 : 8'h00);
      step();
    end
    fact = 1'b0; fph = 2'd0;
    wr_reg(8'h02, 8'h04);
    step();
    check("R9 idle line no abort", {6'd0, o_abort, o_supp}, 8'h00);
    step(); fph = 2'd3;

    // R3 master reset, with a claim held in Beacon
    inb = 1'b1;
    wr_reg(8'h02, 8'h10);
    step();
    wr_reg(8'h02, 8'h01);
    check("R3 bit0 set", rdata, 8'h11);
    step();
    check("R3 clear strobes", {6'd0, o_cfg, o_tmr}, 8'h03);
    check("R3 sets MAC reset clears claim", rdata, 8'h05);
    step();
    check("R3 MAC reset follows", {7'd0, o_mrst}, 8'h01);
    check("R3 still busy", rdata, 8'h01);
    step();
    check("R3 busy last", rdata, 8'h01);
    step();
    check("R3 all zero", rdata, 8'h00);
    inb = 1'b0;
    step();

    // R5 beacon, R10 external frame gate
    wr_reg(8'h02, 8'h08);
    check("R5 beacon sets MAC reset", rdata, 8'h0C);
    step();
    check("R5 MAC reset first", {o_mrst, o_fb, o_fc}, 8'h04);
    check("R5 beacon kept", rdata, 8'h08);
    step();
    check("R5 beacon force", {o_mrst, o_fb, o_fc}, 8'h02);
    check("R10 no ext before frame", {7'd0, o_ext}, 8'h00);
    step();
    check("R5 single beacon strobe", {7'd0, o_fb}, 8'h00);
    fsent = 1'b1; step(); fsent = 1'b0;
    check("R10 ext after internal frame", {7'd0, o_ext}, 8'h01);
    pulse_enter_beacon();
    check("R5 beacon cleared on entry", rdata, 8'h00);
    wr_reg(8'h02, 8'h04);
    step();
    check("R10 ext dropped on force", {7'd0, o_ext}, 8'h00);
    step();

    // R6 claim
    wr_reg(8'h02, 8'h10);
    check("R6 claim set", rdata, 8'h10);
    step();
    check("R6 claim force", {o_mrst, o_fb, o_fc}, 8'h01);
    step();
    check("R6 claim pending", rdata, 8'h10);
    // R11 rewrite and zero write
    wr_reg(8'h02, 8'h10);
    step();
    check("R11 no second claim", {7'd0, o_fc}, 8'h00);
    wr_reg(8'h02, 8'h00);
    check("R11 zero does not cancel", rdata, 8'h10);
    pulse_enter_claim();
    check("R6 claim cleared on entry", rdata, 8'h00);

    // R7 claim held in Beacon until own beacon returns
    inb = 1'b1;
    wr_reg(8'h02, 8'h10);
    repeat (3) begin
      step();
      check("R7 held in beacon", {7'd0, o_fc}, 8'h00);
    end
    check("R7 still pending", rdata, 8'h10);
    myb = 1'b1; step(); myb = 1'b0;
    check("R7 taken on own beacon", {7'd0, o_fc}, 8'h01);
    pulse_enter_claim();
    inb = 1'b0;
    // R7 beacon bit blocks claim
    wr_reg(8'h02, 8'h18);
    step();
    step();
    check("R7 beacon wins over claim", {o_mrst, o_fb, o_fc}, 8'h02);
    step();
    check("R7 no claim while beacon set", {7'd0, o_fc}, 8'h00);
    pulse_enter_beacon();
    check("R7 entry clears both", rdata, 8'h00);

    // R8 MAC reset between beacon force and entry
    wr_reg(8'h02, 8'h08);
    step(); step();
    check("R8 first beacon force", {7'd0, o_fb}, 8'h01);
    wr_reg(8'h02, 8'h04);
    check("R8 pending both", rdata, 8'h0C);
    step();
    check("R8 reset wins", {o_mrst, o_fb, o_fc}, 8'h04);
    check("R8 beacon not cleared", rdata, 8'h08);
    step();
    check("R8 beacon forced again", {o_mrst, o_fb, o_fc}, 8'h02);
    pulse_enter_beacon();

    // R7 random held/taken combinations
    for (int i = 0; i < 12; i++) begin
      bit rb, rm;
      rb = 1'($urandom); rm = 1'($urandom);
      inb = rb; myb = rm;
      wr_reg(8'h02, 8'h10);
      step();
      check("R7 random claim", {7'd0, o_fc}, {7'd0, claim_taken(rb, rm)});
      inb = 1'b1; myb = 1'b0;
      pulse_enter_claim();
      inb = 1'b0;
      step();
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule